// File: doc/BRIEF.md
# Fixed-Point Dot Product Engine

This block forms the dot product of two seven-element vectors of signed fixed-point numbers. Each element is a 16-bit two's complement value with 6 fractional bits. The block takes one element pair per clock over a valid/ready input. It multiplies the two operands. It drops the low 6 bits of each product, so every term keeps 6 fractional bits before it is summed. The trimmed terms are added in a 29-bit signed accumulator. An internal counter tracks the element position. When the seventh pair is taken, the 29-bit sum is registered and announced by a one-cycle strobe.

The input stream never applies back-pressure. `in_ready` is high in every cycle outside reset, so a pair is accepted on every clock edge where `in_valid` is high and reset is low. The upstream side may hold `in_valid` low for any number of cycles, including in the middle of a vector. Idle cycles do not disturb the partial sum.

The result side has no ready. The consumer must take `res_data` in the cycle where `res_valid` is high. The value is held until the next result replaces it. Vectors may follow each other with no gap, because the first pair of a vector reloads the accumulator.

Top module: `dotp_engine`

## Requirements
- R1: Each operand is 16-bit two's complement with 6 fractional bits. Each product (12 fractional bits) is trimmed by an arithmetic right shift of 6. This is truncation toward negative infinity with no rounding; for example, 1/64 times -1/64 becomes -1/64.
- R2: Negative trimmed products sign-extend into the sum. For example, -1.75 times 1.25 (raw values -112 and 80) contributes -2.1875 (raw -140).
- R3: Every seven accepted pairs form one vector. The result is the sum of their seven trimmed products.
- R4: `res_valid` is high for exactly one cycle. That cycle is the one after the edge that accepts the seventh pair of a vector. `res_data` changes only at that edge and is held until the next result.
- R5: The first pair of each vector loads the accumulator rather than adding to it. A new vector may start on the clock right after the previous seventh pair.
- R6: A cycle with `in_valid` low leaves the partial sum and the element position unchanged.
- R7: A synchronous reset (`rst` high) clears `res_valid`, `res_data` (to 0) and the element position. The next accepted pair is then the first of a vector.
- R8: `res_data` is 29-bit two's complement with 6 fractional bits. It holds every seven-term sum exactly, including seven terms of (-512.0 × -512.0). Those raw operands are -32768, and the raw result is 117440512.
- R9: `in_ready` is high in every cycle where `rst` is low and low while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Element pair present on `in_a`/`in_b` |
| in_ready | output | 1 | Engine takes a pair this cycle (always high outside reset) |
| in_a | input | 16 | First vector element, signed, 6 fractional bits |
| in_b | input | 16 | Second vector element, signed, 6 fractional bits |
| res_valid | output | 1 | One-cycle strobe: `res_data` holds a new dot product |
| res_data | output | 29 | Dot product, signed, 6 fractional bits |

## Verification
A pair accepted at a rising edge affects only internal state at that edge. The one exception is the seventh pair: its result and strobe are due one cycle later, at the same edge that accepts it. A behavioural model in the bench updates on each rising edge from the sampled inputs. At each falling edge the model's expectations for `in_ready`, `res_valid` and `res_data` are compared with the outputs, so every result is checked in exactly the cycle it is due and no other. Directed vectors check the signed example, the truncation corner, the largest-magnitude sum and a reset in mid-vector. Their values are checked at the falling edge after the seventh pair is driven.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int ELEM_W  = 16;
  localparam int FRAC_W  = 6;
  localparam int TERMS   = 7;
  localparam int SUM_W   = 29;
endpackage

// File: rtl/dotp_mul_trim.sv
module dotp_mul_trim #(
  parameter int IN_W   = dotp_pkg::ELEM_W,
  parameter int FRAC_W = dotp_pkg::FRAC_W,
  localparam int PROD_W = 2 * IN_W,
  localparam int TRIM_W = PROD_W - FRAC_W
) (
  input  logic signed [IN_W-1:0]   op_a,
  input  logic signed [IN_W-1:0]   op_b,
  output logic signed [TRIM_W-1:0] term
);
  logic signed [PROD_W-1:0] prod;

  assign prod = op_a * op_b;
  assign term = prod[PROD_W-1:FRAC_W];

  // Arithmetic check of the trimmed term against the full product.
  logic signed [PROD_W:0] back, resid;
  always_comb begin
    back  = {term[TRIM_W-1], term, {FRAC_W{1'b0}}};
    resid = {prod[PROD_W-1], prod} - back;
    // R1
    trunc_floor_chk: assert (resid >= 0 && resid < (1 <<< FRAC_W))
      else $error("trimmed term is not the floor of the product");
  end
endmodule

// File: rtl/dotp_elem_cnt.sv
module dotp_elem_cnt #(
  parameter int TERMS = dotp_pkg::TERMS,
  localparam int CNT_W = (TERMS > 1) ? $clog2(TERMS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic first,
  output logic last
);
  logic [CNT_W-1:0] pos;

  assign first = (pos == '0);
  assign last  = (pos == CNT_W'(TERMS - 1));

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (step) pos <= last ? '0 : pos + 1'b1;
  end

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos <= CNT_W'(TERMS - 1));
  // R6
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos));
endmodule

// File: rtl/dotp_accum.sv
module dotp_accum #(
  parameter int TRIM_W = 26,
  parameter int SUM_W  = dotp_pkg::SUM_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic                    first,
  input  logic                    last,
  input  logic signed [TRIM_W-1:0] term,
  output logic                    res_valid,
  output logic signed [SUM_W-1:0] res_data
);
  logic signed [SUM_W-1:0] term_x, acc, acc_next;

  generate
    if (SUM_W > TRIM_W) begin : g_ext
      assign term_x = {{(SUM_W-TRIM_W){term[TRIM_W-1]}}, term};
    end else begin : g_cut
      assign term_x = term[SUM_W-1:0];
    end
  endgenerate

  assign acc_next = first ? term_x : acc + term_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= step && last;
      if (step) acc <= acc_next;
      if (step && last) res_data <= acc_next;
    end
  end

  // R4
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (step && last) |=> res_valid);
  // R4
  res_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(step && last) |=> !res_valid);
  // R4
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(step && last) |=> $stable(res_data));
  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc));
endmodule

// File: rtl/dotp_engine.sv
module dotp_engine #(
  parameter int ELEM_W = dotp_pkg::ELEM_W,
  parameter int FRAC_W = dotp_pkg::FRAC_W,
  parameter int TERMS  = dotp_pkg::TERMS,
  parameter int SUM_W  = dotp_pkg::SUM_W,
  localparam int TRIM_W = 2 * ELEM_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ELEM_W-1:0] in_a,
  input  logic [ELEM_W-1:0] in_b,
  output logic              res_valid,
  output logic [SUM_W-1:0]  res_data
);
  logic step, first, last;
  logic signed [TRIM_W-1:0] term;
  logic signed [SUM_W-1:0]  sum_q;

  assign in_ready = !rst;
  assign step     = in_valid && in_ready;

  dotp_mul_trim #(.IN_W(ELEM_W), .FRAC_W(FRAC_W)) u_mul (
    .op_a(in_a), .op_b(in_b), .term(term));

  dotp_elem_cnt #(.TERMS(TERMS)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .first(first), .last(last));

  dotp_accum #(.TRIM_W(TRIM_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .step(step), .first(first), .last(last),
    .term(term), .res_valid(res_valid), .res_data(sum_q));

  assign res_data = sum_q;

  // R9
  ready_in_reset_chk: assert property (@(posedge clk) rst |-> !in_ready);
endmodule

// File: tb/sim_dotp_engine.sv
module sim_dotp_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_a = '0, in_b = '0;
  logic res_valid;
  logic [28:0] res_data;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dotp_engine u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .res_valid(res_valid), .res_data(res_data));

  // Behavioural reference model
  int    m_pos = 0;
  longint m_sum = 0;
  bit    m_valid = 0;
  longint m_res = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_sum = 0; m_valid = 0; m_res = 0;
    end else begin
      m_valid = 0;
      if (in_valid) begin
        longint t;
        t = (longint'($signed(in_a)) * longint'($signed(in_b))) >>> 6;
        m_sum = (m_pos == 0) ? t : m_sum + t;
        if (m_pos == 6) begin
          m_res = m_sum; m_valid = 1; m_pos = 0;
        end else m_pos = m_pos + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison at the falling edge
  always @(negedge clk) if (!done) begin
    logic [28:0] e;
    e = m_res[28:0];
    check(in_ready == !rst, "R9 ready", in_ready, !rst);
    check(res_valid == m_valid, "R4 strobe", res_valid, m_valid);
    check(res_data == e, "R3 result", $signed(res_data), $signed(e));
  end

  task automatic pair(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); in_valid = 1'b1; in_a = a; in_b = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  task automatic vec_same(input logic [15:0] a, input logic [15:0] b);
    for (int i = 0; i < 7; i++) pair(a, b);
  endtask

  task automatic expect_now(input string req, input longint exp);
    logic [28:0] e;
    e = exp[28:0];
    @(negedge clk); in_valid = 1'b0;
    check(res_valid === 1'b1, {req, " strobe"}, res_valid, 1);
    check(res_data === e, req, $signed(res_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(res_valid === 1'b0, "R7 valid in reset", res_valid, 0);
    check(res_data === '0, "R7 data in reset", res_data, 0);
    check(in_ready === 1'b0, "R9 ready in reset", in_ready, 0);
    rst = 1'b0;

    // R2: -1.75 * 1.25 -> -2.1875 (raw -140), other terms zero
    pair(16'hFF90, 16'd80);
    for (int i = 0; i < 6; i++) pair(16'd0, 16'd123);
    expect_now("R2 signed product", -140);

    // R1: 1/64 * -1/64 floors to -1/64, seven times
    vec_same(16'd1, 16'hFFFF);
    expect_now("R1 floor truncation", -7);

    // R8: largest magnitude, back to back with R5
    vec_same(16'h8000, 16'h8000);
    expect_now("R8 full scale", 117440512);
    vec_same(16'h8000, 16'h7FFF);
    expect_now("R5 back-to-back reload", -7 * 16777216 + 7 * 512);

    // R6: gaps inside a vector
    for (int i = 0; i < 7; i++) begin
      pair(16'd64, 16'(i * 64));
      idle(i % 3);
    end
    expect_now("R6 gaps ignored", 21 * 64);

    // R7: reset mid-vector restarts the count
    pair(16'd640, 16'd640); pair(16'd640, 16'd640); pair(16'd640, 16'd640);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(res_data === '0, "R7 data cleared", res_data, 0);
    vec_same(16'd128, 16'd192);
    expect_now("R7 fresh vector after reset", 7 * 384);

    // R3/R5: random vectors, back to back and with gaps
    for (int v = 0; v < 300; v++) begin
      for (int i = 0; i < 7; i++) begin
        pair(16'($urandom), 16'($urandom));
        if (v % 4 == 1) idle($urandom_range(0, 2));
      end
    end
    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule